// File: doc/BRIEF.md
# Vector Register Redirection Table

This block holds a small programmable set of configuration slots. Each slot describes how an instruction's reference to one architectural register should be understood. A slot names a register file (integer or floating point) and a register number. For that register it supplies a replacement starting register, an element-width code, a vector flag, a packed-SIMD flag and a bank bit. From the slots the block keeps two 32-record lookup tables, one per register file. The instruction decoder queries these tables with a register number and a file select.

Slots may overlap. Several slots can name the same register, so that register has several possible interpretations. The table is rebuilt by walking the slots from the lowest index to the highest, so the highest-indexed active slot that names a register decides its record. A register that no active slot names keeps its plain scalar meaning: it maps to itself, with the default width and every flag clear. Software loads slots through a simple write port. The tables follow one clock after the write, and a decoder lookup is returned one clock after it is presented.

Top module: `vremap_table`

## Requirements
- R1: A cycle with `wr_en` high stores `wr_data` into slot `wr_idx`, with this bit layout: bit 0 file select (0 integer, 1 floating point), bits 5:1 key register, bits 10:6 target register, bits 12:11 element-width code, bit 13 vector flag, bit 14 packed-SIMD flag, bit 15 bank bit.
- R2: After reset the lookup outputs are all zero, every slot is inactive, and every lookup in both files returns the identity record.
- R3: A register that no active slot names returns the identity record: target equal to the queried register, width code 0, vector, packed-SIMD and bank all 0.
- R4: A register named by an active slot returns that slot's target, width code and three flags. The slot affects only the file given by its file-select bit, and the same register number in the other file is unaffected.
- R5: When several active slots name the same file and register, the slot with the highest index decides the record, whatever order the slots were written in.
- R6: A lookup presented in one cycle appears on the outputs after the next rising edge. A write's effect is visible to a lookup presented two cycles after the write cycle. A lookup presented in the cycle immediately after the write still returns the old record.
- R7: A slot becomes active the first time it is written and stays active until reset. Slots not written since reset have no effect, even though their cleared contents would name integer register 0.
- R8: Rewriting a slot replaces its whole contents. A register that the slot named before, and that no other active slot names, falls back to the next lower matching slot, or to the identity record if there is none.
- R9: The element-width code is passed through unchanged (0 default, 1 half of default, 2 eight bits, 3 sixteen bits), and so is the bank bit, including the reserved value 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 4 | Slot index to write |
| wr_data | input | 16 | Slot contents, layout as in R1 |
| rd_file | input | 1 | Lookup file select, 0 integer, 1 floating point |
| rd_reg | input | 5 | Lookup architectural register |
| rd_target | output | 5 | Redirected starting register |
| rd_elw | output | 2 | Element-width code |
| rd_vec | output | 1 | Vector flag |
| rd_simd | output | 1 | Packed-SIMD flag |
| rd_bank | output | 1 | Bank bit |

## Verification
The assertions take for granted that `wr_idx` always names an existing slot, and that `wr_en`, `rd_file` and `rd_reg` are driven to known values from reset onward. The hold properties also assume the lookup address changes only when the decoder means it to. The stimulus drives every input away from the rising edge and draws slot indices from the valid range only. It picks keys mostly from a handful of registers so that overlapping slots arise often. It waits for the tables to settle before a random lookup, except in the directed case that probes the cycle right after a write.

// File: rtl/vremap_pkg.sv
`timescale 1ns/1ps
package vremap_pkg;
  localparam int REG_W     = 5;
  localparam int NUM_REGS  = 1 << REG_W;
  localparam int NUM_FILES = 2;
  localparam int ENTRY_W   = 16;

  typedef enum logic [1:0] {
    ELW_DEFAULT = 2'd0,
    ELW_HALF    = 2'd1,
    ELW_8       = 2'd2,
    ELW_16      = 2'd3
  } elw_e;

  // slot layout, MSB first: bank, simd, vec, elw, target, key, file
  typedef struct packed {
    logic             bank;
    logic             simd;
    logic             vec;
    elw_e             elw;
    logic [REG_W-1:0] target;
    logic [REG_W-1:0] key;
    logic             file;
  } slot_t;

  typedef struct packed {
    logic             bank;
    logic             simd;
    logic             vec;
    elw_e             elw;
    logic [REG_W-1:0] target;
  } rec_t;

  typedef rec_t [NUM_REGS-1:0] table_t;

  function automatic rec_t identity_rec(input logic [REG_W-1:0] r);
    rec_t x;
    x.bank   = 1'b0;
    x.simd   = 1'b0;
    x.vec    = 1'b0;
    x.elw    = ELW_DEFAULT;
    x.target = r;
    return x;
  endfunction

  function automatic rec_t slot_rec(input slot_t s);
    rec_t x;
    x.bank   = s.bank;
    x.simd   = s.simd;
    x.vec    = s.vec;
    x.elw    = s.elw;
    x.target = s.target;
    return x;
  endfunction

  function automatic table_t identity_table();
    table_t t;
    for (int i = 0; i < NUM_REGS; i++) t[i] = identity_rec(REG_W'(i));
    return t;
  endfunction
endpackage

// File: rtl/vremap_slot_store.sv
`timescale 1ns/1ps
module vremap_slot_store
  import vremap_pkg::*;
#(
  parameter  int NUM_SLOTS = 16,
  localparam int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [ENTRY_W-1:0]        wr_data,
  output slot_t [NUM_SLOTS-1:0]     slots_o,
  output logic  [NUM_SLOTS-1:0]     active_o
);
  logic slot_write;
  assign slot_write = wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots_o  <= '0;
      active_o <= '0;
    end else if (slot_write) begin
      slots_o[wr_idx]  <= slot_t'(wr_data);
      active_o[wr_idx] <= 1'b1;
    end
  end

  // R1: the addressed slot holds the written word after the edge
  assert_slot_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_write |=> (ENTRY_W'(slots_o[$past(wr_idx)]) == $past(wr_data)));

  // R7: once active, a slot stays active until reset
  assert_active_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((active_o & $past(active_o)) == $past(active_o)));

  // R7: only the written slot can become active
  assert_one_activation_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(active_o & ~$past(active_o)) <= 1));
endmodule

// File: rtl/vremap_table_build.sv
`timescale 1ns/1ps
module vremap_table_build
  import vremap_pkg::*;
#(
  parameter int NUM_SLOTS = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  slot_t [NUM_SLOTS-1:0]     slots_i,
  input  logic  [NUM_SLOTS-1:0]     active_i,
  output table_t [NUM_FILES-1:0]    tables_o
);
  logic config_steady;
  assign config_steady = 1'b1;

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
    table_t next_tbl;

    // ascending scan: a later slot overwrites an earlier one (R5)
    always_comb begin
      next_tbl = identity_table();
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (active_i[s] && (slots_i[s].file == 1'(f)))
          next_tbl[slots_i[s].key] = slot_rec(slots_i[s]);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tables_o[f] <= identity_table();
      else        tables_o[f] <= next_tbl;
    end

    // R2: with no active slot the table settles to identity
    assert_quiet_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i == '0) |=> (tables_o[f] == identity_table()));
  end

  // R6: unchanged slots leave the tables unchanged one cycle later
  assert_table_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (config_steady && $stable(slots_i) && $stable(active_i)) |=> $stable(tables_o));
endmodule

// File: rtl/vremap_lookup.sv
`timescale 1ns/1ps
module vremap_lookup
  import vremap_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  table_t [NUM_FILES-1:0]    tables_i,
  input  logic                      rd_file,
  input  logic [REG_W-1:0]          rd_reg,
  output rec_t                      rec_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rec_o <= '0;
    else        rec_o <= tables_i[rd_file][rd_reg];
  end

  // R6: same query against an unchanged table gives the same answer
  assert_lookup_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_file) && $stable(rd_reg) && $stable(tables_i)) |=> $stable(rec_o));
endmodule

// File: rtl/vremap_table.sv
`timescale 1ns/1ps
module vremap_table
  import vremap_pkg::*;
#(
  parameter  int NUM_SLOTS = 16,
  localparam int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [15:0]        wr_data,
  input  logic               rd_file,
  input  logic [4:0]         rd_reg,
  output logic [4:0]         rd_target,
  output logic [1:0]         rd_elw,
  output logic               rd_vec,
  output logic               rd_simd,
  output logic               rd_bank
);
  slot_t  [NUM_SLOTS-1:0] slots;
  logic   [NUM_SLOTS-1:0] active;
  table_t [NUM_FILES-1:0] tables;
  rec_t                   rec;

  vremap_slot_store #(.NUM_SLOTS(NUM_SLOTS)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .slots_o  (slots),
    .active_o (active)
  );

  vremap_table_build #(.NUM_SLOTS(NUM_SLOTS)) u_build (
    .clk      (clk),
    .rst_n    (rst_n),
    .slots_i  (slots),
    .active_i (active),
    .tables_o (tables)
  );

  vremap_lookup u_lookup (
    .clk      (clk),
    .rst_n    (rst_n),
    .tables_i (tables),
    .rd_file  (rd_file),
    .rd_reg   (rd_reg),
    .rec_o    (rec)
  );

  assign rd_target = rec.target;
  assign rd_elw    = rec.elw;
  assign rd_vec    = rec.vec;
  assign rd_simd   = rec.simd;
  assign rd_bank   = rec.bank;
endmodule

// File: tb/vremap_table_bench.sv
`timescale 1ns/1ps
module vremap_table_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic        rd_file = 1'b0;
  logic [4:0]  rd_reg = '0;
  logic [4:0]  rd_target;
  logic [1:0]  rd_elw;
  logic        rd_vec, rd_simd, rd_bank;

  int tests = 0;
  int fails = 0;
  logic [15:0] m_slot [16];
  bit          m_act  [16];

  always #2 clk = ~clk;

  vremap_table u_vremap_table (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_file(rd_file), .rd_reg(rd_reg), .rd_target(rd_target), .rd_elw(rd_elw),
    .rd_vec(rd_vec), .rd_simd(rd_simd), .rd_bank(rd_bank)
  );

  function automatic logic [15:0] mk(input bit file, input int key, input int tgt,
                                     input int elw, input bit vec, input bit simd, input bit bank);
    return {bank, simd, vec, 2'(elw), 5'(tgt), 5'(key), file};
  endfunction

  // expected record {bank,simd,vec,elw,target}
  function automatic logic [9:0] expect_rec(input bit file, input logic [4:0] r);
    logic [9:0] e = {5'b0, r};
    for (int i = 0; i < 16; i++)
      if (m_act[i] && m_slot[i][0] == file && m_slot[i][5:1] == r)
        e = {m_slot[i][15], m_slot[i][14], m_slot[i][13], m_slot[i][12:11], m_slot[i][10:6]};
    return e;
  endfunction

  function automatic logic [9:0] got_rec();
    return {rd_bank, rd_simd, rd_vec, rd_elw, rd_target};
  endfunction

  task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(input int idx, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
    @(posedge clk);
    m_slot[idx] = d; m_act[idx] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic lookup(input string req, input bit file, input int r);
    rd_file = file; rd_reg = 5'(r);
    @(posedge clk);
    @(negedge clk);
    check(req, got_rec(), expect_rec(file, 5'(r)));
  endtask

  function automatic int pick_key();
    return ($urandom % 4 != 0) ? int'($urandom % 4) : int'($urandom % 32);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 16; i++) begin m_slot[i] = '0; m_act[i] = 1'b0; end
    repeat (3) @(negedge clk);
    check("R2 reset outputs", got_rec(), 10'd0);
    rst_n = 1'b1;
    @(negedge clk);
    lookup("R2 identity int 5", 1'b0, 5);
    lookup("R2 identity fp 31", 1'b1, 31);
    lookup("R3 identity int 0", 1'b0, 0);

    // R1/R4 basic mapping, width code 2
    do_write(3, mk(0, 7, 20, 2, 1, 0, 0));
    settle();
    lookup("R4 int 7 mapped", 1'b0, 7);
    check("R1 int 7 fields", got_rec(), {1'b0, 1'b0, 1'b1, 2'd2, 5'd20});
    lookup("R4 fp 7 untouched", 1'b1, 7);
    lookup("R3 int 8 unmapped", 1'b0, 8);

    // R7: slot 2 maps int 0; unwritten higher slots must not override
    do_write(2, mk(0, 0, 11, 1, 0, 1, 0));
    settle();
    lookup("R7 int 0 from slot 2", 1'b0, 0);
    check("R7 int 0 target", {5'b0, rd_target}, 10'd11);

    // R6 timing: lookup held on int 9 across a write
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd4; wr_data = mk(0, 9, 1, 3, 1, 1, 1);
    rd_file = 1'b0; rd_reg = 5'd9;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R6 old record cycle after write", got_rec(), {5'b0, 5'd9});
    m_slot[4] = mk(0, 9, 1, 3, 1, 1, 1); m_act[4] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R6 new record two cycles after", got_rec(), expect_rec(0, 5'd9));
    check("R9 bank and width pass through", got_rec(), {1'b1, 1'b1, 1'b1, 2'd3, 5'd1});

    // R5 overlap: higher slot wins, regardless of write order
    do_write(10, mk(0, 7, 2, 1, 0, 1, 0));
    settle();
    lookup("R5 slot 10 over slot 3", 1'b0, 7);
    check("R5 target 2", {5'b0, rd_target}, 10'd2);
    do_write(1, mk(0, 7, 30, 0, 1, 0, 0));
    settle();
    lookup("R5 late low slot loses", 1'b0, 7);
    check("R5 target still 2", {5'b0, rd_target}, 10'd2);

    // R8 rewrite slot 10 to fp: int 7 falls back to slot 3
    do_write(10, mk(1, 7, 17, 2, 1, 0, 1));
    settle();
    lookup("R8 int 7 falls back", 1'b0, 7);
    check("R8 target 20", {5'b0, rd_target}, 10'd20);
    lookup("R8 fp 7 new slot", 1'b1, 7);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int nw = 1 + int'($urandom % 3);
      for (int w = 0; w < nw; w++)
        do_write(int'($urandom % 16),
                 mk(1'($urandom), pick_key(), int'($urandom % 32), int'($urandom % 4),
                    1'($urandom), 1'($urandom), 1'($urandom)));
      settle();
      for (int q = 0; q < 4; q++)
        lookup("R3 R4 R5 R8 random", 1'($urandom), pick_key());
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule